// File: doc/BRIEF.md
# Banked Program Memory Address Mapper

This block sits between a CPU with a 16-bit address bus and the program storage behind it. It turns CPU addresses from 0x6000 to 0xFFFF into a banked ROM address or a banked RAM address with a chip select. RAM can be spread over two chips. Each CPU cycle gets exactly one of three results: the ROM is selected, the RAM is selected, or neither is selected.

Software sets up the mapping by writing to a small group of registers in the 0x5100 page over the same write bus. These registers are a 2-bit layout mode, one page register for the fixed RAM window at 0x6000, four bank registers for the upper 32 KB, and two key registers. The key registers must hold a fixed pair of values before any RAM write is passed on. Address decoding is combinational. A register write takes effect at the next clock edge.

Top module: `prgBankMapper`

## Requirements
- R1: After reset the layout mode is 3 (four 8 KB banks). The bank register for 0xE000 holds 0xFF. The other three bank registers, the window page and both key registers hold 0. So 0xE000 maps to ROM page 0x7F and RAM writes are locked.
- R2: Addresses 0x6000–0x7FFF always select RAM. Window page bit 2 drives the chip select. Page bits 1:0 are the upper two bits of the 15-bit RAM address, and CPU address bits 12:0 are the lower bits.
- R3: Addresses below 0x6000 select neither ROM nor RAM. Neither write enable nor any select is asserted for them.
- R4: In mode 0 the whole 0x8000–0xFFFF range comes from the 0xE000 bank register as one 32 KB bank. Page bits 1:0 are replaced by CPU address bits 14:13.
- R5: In mode 1, 0x8000–0xBFFF comes from the 0xA000 bank register and 0xC000–0xFFFF comes from the 0xE000 bank register. Both are 16 KB banks, and page bit 0 is replaced by CPU address bit 13.
- R6: In mode 2, 0x8000–0xBFFF is a 16 KB bank from the 0xA000 register. 0xC000–0xDFFF and 0xE000–0xFFFF are 8 KB banks from their own registers.
- R7: In mode 3, each 8 KB slot from 0x8000 upward uses its own register: offsets 0x14, 0x15, 0x16 and 0x17 from 0x5100.
- R8: In the 0x8000, 0xA000 and 0xC000 registers, bit 7 = 1 selects ROM and bit 7 = 0 selects RAM. Bits 6:0 give the 8 KB page number. The ROM address is {page, CPU bits 12:0}. For RAM, page bit 2 is the chip select and page bits 1:0 lead the 15-bit RAM address.
- R9: The 0xE000 register always selects ROM, whatever its bit 7 holds.
- R10: The RAM write enable is high only on a CPU write to a RAM-selected address while key A (0x5102, bits 1:0) holds 2'b10 and key B (0x5103, bits 1:0) holds 2'b01. Any other pair blocks every RAM write.
- R11: While the keys are locked, RAM-mapped addresses still assert the RAM select and address, so reads work.
- R12: A write to 0x5100 (mode bits 1:0), 0x5113 (window page bits 2:0) or 0x5114–0x5117 (bank registers) changes the decode from the next cycle on. Writes to other addresses in the register page, such as 0x5101, 0x5112 and 0x5118, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuWe | input | 1 | CPU write strobe, for register writes and memory writes |
| cpuData | input | 8 | CPU write data |
| romSel | output | 1 | ROM selected for this address |
| romAddr | output | 20 | Banked ROM byte address |
| ramSel | output | 1 | RAM selected for this address |
| ramChip | output | 1 | RAM chip select (0 or 1) |
| ramAddr | output | 15 | Byte address inside the selected RAM chip |
| ramWe | output | 1 | RAM write enable |

## Verification
The bench programs random bank values in every layout mode and probes addresses in every slot.

- A design that forgets to substitute the CPU address bits in 16 KB or 32 KB banks returns the same page for both halves of a bank.
- A design that honours bit 7 of the 0xE000 register puts RAM at the reset vector.

Key checks cover:
- the accepted pair;
- pairs that are wrong in only one register;
- a key with junk in its upper bits.

A mapper that compares whole bytes or only one key would let a write through or block one. Writes to neighbouring register addresses are checked so that a decoder that matches too few address bits shows up as a changed mapping.

// File: rtl/prgMapPkg.sv
package prgMapPkg;
  localparam int DATA_W    = 8;
  localparam int NUM_BANKS = 4;

  typedef enum logic [1:0] {
    MAP_32K    = 2'd0,
    MAP_16K    = 2'd1,
    MAP_16K_8K = 2'd2,
    MAP_8K     = 2'd3
  } mapMode_e;

  typedef struct packed {
    logic                  wrMode;
    logic                  wrRamPage;
    logic                  wrKeyA;
    logic                  wrKeyB;
    logic [NUM_BANKS-1:0]  wrBank;
    logic [DATA_W-1:0]     data;
  } regStrobe_t;
endpackage

// File: rtl/prgMapCtrl.sv
module prgMapCtrl
  import prgMapPkg::*;
#(
  parameter logic [15:0] REG_BASE = 16'h5100
) (
  input  logic [15:0]       cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuData,
  output regStrobe_t        strobe
);
  localparam logic [15:0] MODE_ADDR  = REG_BASE;
  localparam logic [15:0] KEYA_ADDR  = REG_BASE + 16'h0002;
  localparam logic [15:0] KEYB_ADDR  = REG_BASE + 16'h0003;
  localparam logic [15:0] PAGE_ADDR  = REG_BASE + 16'h0013;
  localparam logic [15:0] BANK0_ADDR = REG_BASE + 16'h0014;

  logic [NUM_BANKS-1:0] bankHit;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bankHit
    assign bankHit[i] = cpuWe && (cpuAddr == BANK0_ADDR + 16'(i));
  end

  always_comb begin
    strobe.wrMode    = cpuWe && (cpuAddr == MODE_ADDR);
    strobe.wrRamPage = cpuWe && (cpuAddr == PAGE_ADDR);
    strobe.wrKeyA    = cpuWe && (cpuAddr == KEYA_ADDR);
    strobe.wrKeyB    = cpuWe && (cpuAddr == KEYB_ADDR);
    strobe.wrBank    = bankHit;
    strobe.data      = cpuData;
  end
endmodule

// File: rtl/prgMapDatapath.sv
module prgMapDatapath
  import prgMapPkg::*;
#(
  parameter  int OFF_W      = 13,
  parameter  int RAM_PAGE_W = 2,
  localparam int ROM_PAGE_W = DATA_W - 1,
  localparam int ROM_AW     = ROM_PAGE_W + OFF_W,
  localparam int RAM_AW     = RAM_PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [15:0]       cpuAddr,
  input  logic              cpuWe,
  output logic              romSel,
  output logic [ROM_AW-1:0] romAddr,
  output logic              ramSel,
  output logic              ramChip,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWe
);
  localparam int HI_W = 16 - OFF_W;
  localparam logic [1:0] LAST_IDX = 2'(NUM_BANKS - 1);

  mapMode_e                        mode;
  logic [RAM_PAGE_W:0]             winPage;
  logic [1:0]                      keyA, keyB;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bankReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MAP_8K;
      winPage <= '0;
      keyA    <= '0;
      keyB    <= '0;
      for (int b = 0; b < NUM_BANKS; b++)
        bankReg[b] <= (b == NUM_BANKS - 1) ? '1 : '0;
    end else begin
      if (strobe.wrMode)    mode    <= mapMode_e'(strobe.data[1:0]);
      if (strobe.wrRamPage) winPage <= strobe.data[RAM_PAGE_W:0];
      if (strobe.wrKeyA)    keyA    <= strobe.data[1:0];
      if (strobe.wrKeyB)    keyB    <= strobe.data[1:0];
      for (int b = 0; b < NUM_BANKS; b++)
        if (strobe.wrBank[b]) bankReg[b] <= strobe.data;
    end
  end

  // Slot-to-register selection and bank-size substitution
  logic [1:0]            slot, regIdx, span;
  logic [DATA_W-1:0]     selReg;
  logic [ROM_PAGE_W-1:0] page;
  logic                  toRom;

  always_comb begin
    slot = cpuAddr[OFF_W+1:OFF_W];
    unique case (mode)
      MAP_32K:    begin regIdx = LAST_IDX;                   span = 2'd2; end
      MAP_16K:    begin regIdx = slot[1] ? LAST_IDX : 2'd1;  span = 2'd1; end
      MAP_16K_8K: begin regIdx = slot[1] ? slot : 2'd1;      span = slot[1] ? 2'd0 : 2'd1; end
      default:    begin regIdx = slot;                       span = 2'd0; end
    endcase
    selReg = bankReg[regIdx];
    page   = selReg[ROM_PAGE_W-1:0];
    if (span != 2'd0) page[0] = cpuAddr[OFF_W];
    if (span == 2'd2) page[1] = cpuAddr[OFF_W+1];
    toRom = selReg[DATA_W-1] || (regIdx == LAST_IDX);
  end

  // Output select and address assembly
  logic [HI_W-1:0]     hiAddr;
  logic                isWindow, isUpper, unlocked;
  logic [RAM_PAGE_W:0] ramPage;

  always_comb begin
    hiAddr   = cpuAddr[15:OFF_W];
    isWindow = (hiAddr == HI_W'(3));
    isUpper  = cpuAddr[15];
    romSel   = isUpper && toRom;
    ramSel   = isWindow || (isUpper && !toRom);
    ramPage  = isWindow ? winPage : page[RAM_PAGE_W:0];
    ramChip  = ramPage[RAM_PAGE_W];
    ramAddr  = {ramPage[RAM_PAGE_W-1:0], cpuAddr[OFF_W-1:0]};
    romAddr  = {page, cpuAddr[OFF_W-1:0]};
    unlocked = (keyA == 2'b10) && (keyB == 2'b01);
    ramWe    = cpuWe && ramSel && unlocked;
  end
endmodule

// File: rtl/prgBankMapper.sv
module prgBankMapper
  import prgMapPkg::*;
#(
  parameter  logic [15:0] REG_BASE   = 16'h5100,
  parameter  int          OFF_W      = 13,
  parameter  int          RAM_PAGE_W = 2,
  localparam int          ROM_AW     = DATA_W - 1 + OFF_W,
  localparam int          RAM_AW     = RAM_PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuData,
  output logic              romSel,
  output logic [ROM_AW-1:0] romAddr,
  output logic              ramSel,
  output logic              ramChip,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWe
);
  regStrobe_t strobe;

  prgMapCtrl #(.REG_BASE(REG_BASE)) u_ctrl (
    .cpuAddr(cpuAddr),
    .cpuWe  (cpuWe),
    .cpuData(cpuData),
    .strobe (strobe)
  );

  prgMapDatapath #(.OFF_W(OFF_W), .RAM_PAGE_W(RAM_PAGE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cpuAddr(cpuAddr),
    .cpuWe  (cpuWe),
    .romSel (romSel),
    .romAddr(romAddr),
    .ramSel (ramSel),
    .ramChip(ramChip),
    .ramAddr(ramAddr),
    .ramWe  (ramWe)
  );
endmodule

// File: rtl/prgMapChecker.sv
module prgMapChecker
  import prgMapPkg::*;
#(
  parameter logic [15:0] REG_BASE = 16'h5100,
  parameter int          OFF_W    = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [15:0]       cpuAddr,
  input logic              cpuWe,
  input logic [1:0]        keyBits,
  input logic              romSel,
  input logic              ramSel,
  input logic              ramWe,
  input logic [DATA_W-2:0] romPage
);
  localparam int HI_W = 16 - OFF_W;

  // Independent shadow of the unlock key pair, built from the write bus
  logic [1:0] shKeyA, shKeyB;
  logic       keyOk;
  logic [HI_W-1:0] hiAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shKeyA <= '0;
      shKeyB <= '0;
    end else if (cpuWe) begin
      if (cpuAddr == REG_BASE + 16'h0002) shKeyA <= keyBits;
      if (cpuAddr == REG_BASE + 16'h0003) shKeyB <= keyBits;
    end
  end

  assign keyOk  = (shKeyA == 2'b10) && (shKeyB == 2'b01);
  assign hiAddr = cpuAddr[15:OFF_W];

  a_r1_reset_top_page: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!rstN) && hiAddr == '1) |-> (romSel && romPage == '1));

  a_r2_window_is_ram: assert property (@(posedge clk) disable iff (!rstN)
    (hiAddr == HI_W'(3)) |-> (ramSel && !romSel));

  a_r3_low_space_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr < 16'h6000) |-> (!romSel && !ramSel && !ramWe));

  a_r8_upper_one_target: assert property (@(posedge clk) disable iff (!rstN)
    cpuAddr[15] |-> ($countones({romSel, ramSel}) == 1));

  a_r9_top_always_rom: assert property (@(posedge clk) disable iff (!rstN)
    (hiAddr == '1) |-> romSel);

  a_r10_write_needs_key: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (keyOk && cpuWe));

  a_r10_key_opens_write: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && ramSel && keyOk) |-> ramWe);

  a_r11_locked_read_only: assert property (@(posedge clk) disable iff (!rstN)
    (ramSel && !keyOk) |-> !ramWe);
endmodule

bind prgBankMapper prgMapChecker #(.REG_BASE(REG_BASE), .OFF_W(OFF_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .cpuAddr(cpuAddr),
  .cpuWe  (cpuWe),
  .keyBits(cpuData[1:0]),
  .romSel (romSel),
  .ramSel (ramSel),
  .ramWe  (ramWe),
  .romPage(romAddr[ROM_AW-1:OFF_W])
);

// File: tb/sim_prgBankMapper.sv
module sim_prgBankMapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] cpuAddr;
  logic        cpuWe;
  logic [7:0]  cpuData;
  logic        romSel, ramSel, ramChip, ramWe;
  logic [19:0] romAddr;
  logic [14:0] ramAddr;

  prgBankMapper u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuData(cpuData),
    .romSel(romSel), .romAddr(romAddr), .ramSel(ramSel), .ramChip(ramChip),
    .ramAddr(ramAddr), .ramWe(ramWe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [15:0] addr;
    logic        romS, ramS, chip, we;
    logic [19:0] rA;
    logic [14:0] mA;
    string       tag;
  } item_t;

  item_t sbQ[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  // Bench shadow of the register state, per the requirements
  logic [1:0] mMode;
  logic [2:0] mPage;
  logic [1:0] mKeyA, mKeyB;
  logic [7:0] mBank[4];

  function automatic item_t predict(logic [15:0] a, logic we, string tag);
    item_t it;
    int r, sz, slotIdx, pg, off;
    logic [7:0] v;
    it.addr = a; it.tag = tag;
    it.romS = 0; it.ramS = 0; it.chip = 0; it.we = 0; it.rA = '0; it.mA = '0;
    off = int'(a) % 8192;
    r = 0; sz = 1;
    if (a >= 16'h8000) begin
      slotIdx = (int'(a) - 32'h8000) >> 13;
      case (mMode)
        2'd0: begin r = 3; sz = 4; end
        2'd1: begin r = (slotIdx >= 2) ? 3 : 1; sz = 2; end
        2'd2: if (slotIdx < 2) begin r = 1; sz = 2; end
              else begin r = slotIdx; sz = 1; end
        default: begin r = slotIdx; sz = 1; end
      endcase
      v  = mBank[r];
      pg = (int'(v & 8'h7F) & ~(sz - 1)) | (slotIdx & (sz - 1));
      if (r == 3 || v[7]) begin
        it.romS = 1; it.rA = 20'(pg * 8192 + off);
      end else begin
        it.ramS = 1; it.chip = pg[2]; it.mA = 15'((pg % 4) * 8192 + off);
      end
    end else if (a >= 16'h6000) begin
      it.ramS = 1; it.chip = mPage[2];
      it.mA = 15'(int'(mPage[1:0]) * 8192 + off);
    end
    it.we = we && it.ramS && (mKeyA == 2'b10) && (mKeyB == 2'b01);
    return it;
  endfunction

  task automatic probe(logic [15:0] a, logic we, string tag);
    @(negedge clk);
    cpuAddr = a; cpuWe = we; cpuData = 8'h00;
    sbQ.push_back(predict(a, we, tag));
  endtask

  task automatic regWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWe = 1'b1; cpuData = d;
    case (a)
      16'h5100: mMode = d[1:0];
      16'h5102: mKeyA = d[1:0];
      16'h5103: mKeyB = d[1:0];
      16'h5113: mPage = d[2:0];
      16'h5114: mBank[0] = d;
      16'h5115: mBank[1] = d;
      16'h5116: mBank[2] = d;
      16'h5117: mBank[3] = d;
      default: ;
    endcase
  endtask

  // Monitor: pops one expectation per cycle, samples mid-low phase
  initial begin
    item_t it;
    bit bad;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sbQ.size() > 0) begin
        it = sbQ.pop_front();
        checks++;
        bad = (romSel !== it.romS) || (ramSel !== it.ramS) || (ramWe !== it.we) ||
              (it.romS && romAddr !== it.rA) ||
              (it.ramS && (ramChip !== it.chip || ramAddr !== it.mA));
        if (bad) begin
          fails++;
          $display("FAIL %s addr=%h got rom=%b romA=%h ram=%b chip=%b ramA=%h we=%b exp rom=%b romA=%h ram=%b chip=%b ramA=%h we=%b",
                   it.tag, it.addr, romSel, romAddr, ramSel, ramChip, ramAddr, ramWe,
                   it.romS, it.rA, it.ramS, it.chip, it.mA, it.we);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cpuAddr = '0; cpuWe = 1'b0; cpuData = '0;
    mMode = 2'd3; mPage = '0; mKeyA = '0; mKeyB = '0;
    mBank[0] = 8'h00; mBank[1] = 8'h00; mBank[2] = 8'h00; mBank[3] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    probe(16'hE000, 1'b0, "R1");
    probe(16'hFFFF, 1'b0, "R1");
    probe(16'h8000, 1'b0, "R1");
    probe(16'h6000, 1'b1, "R1");

    // R3: below the window
    probe(16'h0000, 1'b0, "R3");
    probe(16'h5FFF, 1'b1, "R3");
    probe(16'h4020, 1'b0, "R3");

    // R2: fixed RAM window
    regWrite(16'h5113, 8'h05);
    probe(16'h6ABC, 1'b0, "R2");
    regWrite(16'h5113, 8'hFA);
    probe(16'h7FFF, 1'b0, "R2");

    // R4..R7: each layout mode with random bank contents
    for (int m = 0; m < 4; m++) begin
      string tg;
      tg = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R7";
      regWrite(16'h5100, 8'(m));
      for (int s = 0; s < 6; s++) begin
        for (int b = 0; b < 4; b++) regWrite(16'(16'h5114 + b), 8'($urandom));
        regWrite(16'h5113, 8'($urandom));
        for (int p = 0; p < 4; p++) begin
          probe(16'(16'h8000 + p * 16'h2000 + ($urandom % 8192)), 1'($urandom), tg);
        end
        probe(16'(16'h6000 + ($urandom % 8192)), 1'b0, tg);
      end
    end

    // R9: top register ignores its ROM/RAM bit (mode 3 still active)
    regWrite(16'h5117, 8'h12);
    probe(16'hE345, 1'b0, "R9");
    probe(16'hFFFC, 1'b1, "R9");

    // R8: per-slot ROM/RAM choice
    regWrite(16'h5115, 8'h05);
    probe(16'hA010, 1'b0, "R8");
    regWrite(16'h5115, 8'h85);
    probe(16'hA010, 1'b0, "R8");
    regWrite(16'h5116, 8'h7B);
    probe(16'hC777, 1'b0, "R8");

    // R10: unlock key
    regWrite(16'h5114, 8'h03);
    regWrite(16'h5102, 8'h02);
    regWrite(16'h5103, 8'h01);
    probe(16'h6000, 1'b1, "R10");
    probe(16'h8123, 1'b1, "R10");
    probe(16'hE000, 1'b1, "R10");
    regWrite(16'h5102, 8'hFE);
    probe(16'h6100, 1'b1, "R10");
    regWrite(16'h5103, 8'h02);
    probe(16'h6100, 1'b1, "R10");
    regWrite(16'h5102, 8'h01);
    regWrite(16'h5103, 8'h01);
    probe(16'h6100, 1'b1, "R10");
    regWrite(16'h5102, 8'h03);
    probe(16'h8100, 1'b1, "R10");

    // R11: locked, RAM reads still mapped
    probe(16'h8004, 1'b0, "R11");
    probe(16'h6004, 1'b0, "R11");

    // R12: neighbours do nothing; real writes apply next cycle
    regWrite(16'h5101, 8'h00);
    regWrite(16'h5112, 8'h00);
    regWrite(16'h5118, 8'h00);
    regWrite(16'h5104, 8'h00);
    probe(16'hE000, 1'b0, "R12");
    probe(16'h6004, 1'b0, "R12");
    regWrite(16'h5100, 8'h00);
    probe(16'h8000, 1'b0, "R12");
    probe(16'hA000, 1'b0, "R12");

    @(negedge clk);
    cpuWe = 1'b0; cpuAddr = '0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule